// File: doc/BRIEF.md
# Parallel Single-Slope Pixel Converter Array with Wide Readout

This block models a digital pixel array in which every pixel converts its own sample at the same time as all the others. A single step counter sweeps the ramp from 0 to 2^CODE_W-1, one step per clock. The Gray-coded form of that count goes to every pixel. Each pixel has a digital comparator and a CODE_W-bit memory. While the comparator has not tripped, the memory copies the broadcast code on every step. On the step where the ramp first reaches the pixel's level, the memory takes that step's code and then holds it. A level above the last ramp step never trips the comparator, so the memory ends up holding the code of the final step.

After the sweep, a readout sequencer streams the held codes out over a BUS_W-bit bus. Each word carries BUS_W/CODE_W neighbouring pixels. Pixels are numbered row-major, and the lowest-numbered pixel of a word sits in its least significant byte. Words leave in ascending order under a valid/ready handshake. A build option converts each code from Gray to binary just before it is packed. A new sweep can only start once the previous frame has been fully read out.

Top module: `ssg_gray_pixel_adc`

## Requirements
- R1: After reset, `busy` and `out_valid` are both 0, and they stay 0 until `start_conv` is sampled high.
- R2: A `start_conv` pulse sampled while idle raises `busy` at the next edge. Exactly 2^CODE_W further rising edges later (256 by default), `out_valid` goes high. `out_valid` stays low for the whole sweep.
- R3: A pixel whose level L is at most 2^CODE_W-1 reads out as the Gray code of L, that is L ^ (L >> 1). For example, level 0 gives 0x00 and level 255 gives 0x80.
- R4: A pixel whose level is 2^CODE_W or higher never trips. It reads out as the Gray code of the last step, which is 0x80 for 8 bits.
- R5: Pixel (row r, column c) has index i = r*COLS + c and takes level bits [i*(CODE_W+1) +: CODE_W+1] of `pix_level`. Its code appears in word i/8, at bits [(i%8)*8 +: 8] of `out_data`.
- R6: Words are offered in ascending order 0 to NPIX/8-1. `out_last` is high only on the final word. A word advances only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_valid` and `out_data` hold steady.
- R7: A `start_conv` pulse while `busy` is high is ignored. The running sweep still takes 2^CODE_W steps, all words are still delivered once, and no extra frame follows.
- R8: When the last word is accepted, `busy` falls at the next edge. The block then accepts a new `start_conv`, and the new frame reflects the levels present during its own sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_conv | input | 1 | Sweep start pulse, honoured only when idle |
| pix_level | input | ROWS*COLS*(CODE_W+1) | Per-pixel input level, held stable during a sweep |
| busy | output | 1 | High from sweep start until the last word is accepted |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Consumer accepts the current word |
| out_data | output | BUS_W | Eight packed pixel codes |
| out_last | output | 1 | Current word is the final word of the frame |

## Verification
A pixel that trips one step early or late, or that keeps loading after it trips, shows up as a wrong byte in the first readout word that carries that pixel. A wrong packing index or a lane swap shows up as a misplaced byte within the first few words. A sequencer that miscounts the sweep moves the rise of `out_valid` away from edge 256. A word index that skips or repeats changes the word sequence, or the position of `out_last`, before the frame ends. A mishandled stray start leaves `busy` high after the last word, or produces an extra frame.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SWEEP = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic clear;
        logic sweep_en;
    } pix_ctl_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ssg_seq_ctrl.sv
module ssg_seq_ctrl
    import ssg_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NWORDS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_conv,
    input  logic                out_ready,
    output pix_ctl_t            pix_ctl,
    output logic [CODE_W-1:0]   step_bin,
    output logic [CODE_W-1:0]   step_gray,
    output logic [((NWORDS > 1) ? $clog2(NWORDS) : 1)-1:0] word_idx,
    output logic                busy,
    output logic                out_valid,
    output logic                out_last
);

    localparam int WI_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [CODE_W-1:0] STEP_LAST = {CODE_W{1'b1}};
    localparam logic [WI_W-1:0] WORD_LAST = WI_W'(NWORDS - 1);

    seq_state_e        state_q;
    logic [CODE_W-1:0] step_q;
    logic [WI_W-1:0]   widx_q;
    logic [31:0]       gray_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            step_q  <= '0;
            widx_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_conv) begin
                        state_q <= SEQ_SWEEP;
                        step_q  <= '0;
                    end
                end
                SEQ_SWEEP: begin
                    if (step_q == STEP_LAST) begin
                        state_q <= SEQ_DRAIN;
                        widx_q  <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                SEQ_DRAIN: begin
                    if (out_ready) begin
                        if (widx_q == WORD_LAST) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        gray_full        = to_gray(32'(step_q));
        step_gray        = gray_full[CODE_W-1:0];
        step_bin         = step_q;
        pix_ctl.clear    = (state_q == SEQ_IDLE) && start_conv;
        pix_ctl.sweep_en = (state_q == SEQ_SWEEP);
        word_idx         = widx_q;
        busy             = (state_q != SEQ_IDLE);
        out_valid        = (state_q == SEQ_DRAIN);
        out_last         = (state_q == SEQ_DRAIN) && (widx_q == WORD_LAST);
    end

endmodule

// File: rtl/ssg_pixel_cell.sv
module ssg_pixel_cell
    import ssg_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  pix_ctl_t            pix_ctl,
    input  logic [CODE_W-1:0]   step_bin,
    input  logic [CODE_W-1:0]   step_gray,
    input  logic [CODE_W:0]     level,
    output logic [CODE_W-1:0]   code
);

    logic              tripped_q;
    logic [CODE_W-1:0] mem_q;
    logic              cmp_hit;

    // digital comparator: ramp has reached the pixel level
    assign cmp_hit = ({1'b0, step_bin} >= level);

    always_ff @(posedge clk) begin
        if (rst) begin
            tripped_q <= 1'b0;
            mem_q     <= '0;
        end else if (pix_ctl.clear) begin
            tripped_q <= 1'b0;
        end else if (pix_ctl.sweep_en && !tripped_q) begin
            mem_q <= step_gray;
            if (cmp_hit) begin
                tripped_q <= 1'b1;
            end
        end
    end

    assign code = mem_q;

endmodule

// File: rtl/ssg_word_pack.sv
module ssg_word_pack
    import ssg_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int NPIX       = 64,
    parameter int PPW        = 8,
    parameter int WI_W       = 3,
    parameter bit OUT_BINARY = 1'b0
) (
    input  logic [NPIX*CODE_W-1:0] codes,
    input  logic [WI_W-1:0]        word_idx,
    output logic [PPW*CODE_W-1:0]  data
);

    logic [PPW*CODE_W-1:0] raw;

    always_comb begin
        raw = '0;
        for (int k = 0; k < PPW; k++) begin
            raw[k*CODE_W +: CODE_W] = codes[(int'(word_idx)*PPW + k)*CODE_W +: CODE_W];
        end
    end

    generate
        if (OUT_BINARY) begin : g_bin
            for (genvar k = 0; k < PPW; k++) begin : g_lane
                logic [31:0] lane_full;
                assign lane_full = from_gray(32'(raw[k*CODE_W +: CODE_W]));
                assign data[k*CODE_W +: CODE_W] = lane_full[CODE_W-1:0];
            end
        end else begin : g_gray
            assign data = raw;
        end
    endgenerate

endmodule

// File: rtl/ssg_gray_pixel_adc.sv
module ssg_gray_pixel_adc
    import ssg_pkg::*;
#(
    parameter int ROWS       = 4,
    parameter int COLS       = 16,
    parameter int CODE_W     = 8,
    parameter int BUS_W      = 64,
    parameter bit OUT_BINARY = 1'b0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start_conv,
    input  logic [ROWS*COLS*(CODE_W+1)-1:0] pix_level,
    output logic                            busy,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [BUS_W-1:0]                out_data,
    output logic                            out_last
);

    localparam int LVL_W  = CODE_W + 1;
    localparam int NPIX   = ROWS * COLS;
    localparam int PPW    = BUS_W / CODE_W;
    localparam int NWORDS = NPIX / PPW;
    localparam int WI_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    pix_ctl_t          pix_ctl;
    logic [CODE_W-1:0] step_bin;
    logic [CODE_W-1:0] step_gray;
    logic [WI_W-1:0]   word_idx;
    logic [NPIX*CODE_W-1:0] codes;

    ssg_seq_ctrl #(
        .CODE_W (CODE_W),
        .NWORDS (NWORDS)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_conv (start_conv),
        .out_ready  (out_ready),
        .pix_ctl    (pix_ctl),
        .step_bin   (step_bin),
        .step_gray  (step_gray),
        .word_idx   (word_idx),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_last   (out_last)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            ssg_pixel_cell #(
                .CODE_W (CODE_W)
            ) cell_i (
                .clk       (clk),
                .rst       (rst),
                .pix_ctl   (pix_ctl),
                .step_bin  (step_bin),
                .step_gray (step_gray),
                .level     (pix_level[IDX*LVL_W +: LVL_W]),
                .code      (codes[IDX*CODE_W +: CODE_W])
            );
        end
    end

    ssg_word_pack #(
        .CODE_W     (CODE_W),
        .NPIX       (NPIX),
        .PPW        (PPW),
        .WI_W       (WI_W),
        .OUT_BINARY (OUT_BINARY)
    ) pack_i (
        .codes    (codes),
        .word_idx (word_idx),
        .data     (out_data)
    );

endmodule

// File: rtl/ssg_gray_pixel_adc_chk.sv
module ssg_gray_pixel_adc_chk #(
    parameter int CODE_W = 8,
    parameter int BUS_W  = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             start_conv,
    input logic             busy,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_data,
    input logic             out_last
);

    localparam int STEPS = 1 << CODE_W;

    logic [CODE_W+1:0] sweep_cyc;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            sweep_cyc <= '0;
        end else if (!out_valid) begin
            sweep_cyc <= sweep_cyc + 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid);

    assert_sweep_length_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (sweep_cyc == (CODE_W+2)'(STEPS)));

    assert_start_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !out_valid);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_stray_start_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start_conv && !(out_valid && out_ready && out_last)) |=> busy);

    assert_drop_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !busy);

endmodule

bind ssg_gray_pixel_adc ssg_gray_pixel_adc_chk #(
    .CODE_W (CODE_W),
    .BUS_W  (BUS_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_conv (start_conv),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
);

// File: tb/ssg_gray_pixel_adc_tb.sv
module ssg_gray_pixel_adc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS   = 4;
    localparam int COLS   = 16;
    localparam int CODE_W = 8;
    localparam int BUS_W  = 64;
    localparam int LVL_W  = CODE_W + 1;
    localparam int NPIX   = ROWS * COLS;
    localparam int PPW    = BUS_W / CODE_W;
    localparam int NWORDS = NPIX / PPW;
    localparam int WD_LIMIT = 100000;

    // frame table: {stall, stray_start, seed[8:0], stride[8:0]}
    localparam int NFRAMES = 6;
    localparam logic [19:0] FRAME_TAB [NFRAMES] = '{
        {1'b0, 1'b0, 9'd0,   9'd1},
        {1'b1, 1'b0, 9'd200, 9'd3},
        {1'b0, 1'b0, 9'd255, 9'd0},
        {1'b0, 1'b0, 9'd256, 9'd0},
        {1'b1, 1'b1, 9'd7,   9'd37},
        {1'b0, 1'b1, 9'd299, 9'd11}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_conv = 1'b0;
    logic [NPIX*LVL_W-1:0] pix_level = '0;
    logic busy;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [BUS_W-1:0] out_data;
    logic out_last;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;
    int lv [NPIX];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ssg_gray_pixel_adc #(
        .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W), .BUS_W(BUS_W), .OUT_BINARY(1'b0)
    ) dut_i (
        .clk(clk), .rst(rst), .start_conv(start_conv), .pix_level(pix_level),
        .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input int l);
        int s;
        s = (l > 255) ? 255 : l;
        return 8'(s ^ (s >> 1));
    endfunction

    function automatic logic [63:0] exp_word(input int w);
        logic [63:0] d;
        d = '0;
        for (int k = 0; k < PPW; k++) d[k*8 +: 8] = exp_code(lv[w*PPW + k]);
        return d;
    endfunction

    task automatic load_levels(input int seed, input int stride);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int i;
                i = r * COLS + c;
                lv[i] = (seed + stride * i) % 300;
                pix_level[i*LVL_W +: LVL_W] = LVL_W'(lv[i]);
            end
        end
    endtask

    // runs one frame; R3/R4/R5 checked per word, R2 on sweep length, R6 on order
    task automatic run_frame(input bit stall, input bit stray, input string tag);
        int n;
        int w;
        int t;
        @(negedge clk);
        start_conv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_conv = 1'b0;
        check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        n = 1;
        t = 0;
        while (!out_valid && n < 400) begin
            if (stray && n == 100) start_conv = 1'b1;
            else start_conv = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start_conv = 1'b0;
        check(n == 257, "R2 sweep edges", 64'(n - 1), 64'd256);
        w = 0;
        while (w < NWORDS && t < 200) begin
            bit rdy;
            rdy = stall ? (((w + t) % 3) != 0) : 1'b1;
            out_ready = rdy;
            start_conv = (stray && w == 2) ? 1'b1 : 1'b0;
            check(out_valid == 1'b1, {"R6 valid ", tag}, 64'(out_valid), 64'd1);
            check(out_data == exp_word(w), {"R3 R4 R5 word ", tag}, out_data, exp_word(w));
            check(out_last == (w == NWORDS - 1), {"R6 last ", tag}, 64'(out_last), 64'(w == NWORDS - 1));
            @(posedge clk);
            if (rdy) w++;
            t++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        start_conv = 1'b0;
        check(busy == 1'b0 && out_valid == 1'b0, {"R8 idle after last ", tag},
              {busy, out_valid}, 64'd0);
        if (stray) begin
            repeat (5) @(posedge clk);
            @(negedge clk);
            check(busy == 1'b0 && out_valid == 1'b0, "R7 no extra frame", {busy, out_valid}, 64'd0);
        end
    endtask

    initial begin
        wait (cyc >= WD_LIMIT);
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        check(out_valid == 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0, "R1 idle holds", {busy, out_valid}, 64'd0);

        for (int f = 0; f < NFRAMES; f++) begin
            logic [19:0] e;
            e = FRAME_TAB[f];
            load_levels(int'(e[17:9]), int'(e[8:0]));
            run_frame(e[19], e[18], $sformatf("frame%0d", f));
        end

        // directed R4 mix: alternating never-trip and zero, plus R8 back-to-back restart
        for (int i = 0; i < NPIX; i++) begin
            lv[i] = (i % 2 == 0) ? 511 : 0;
            pix_level[i*LVL_W +: LVL_W] = LVL_W'(lv[i]);
        end
        run_frame(1'b0, 1'b0, "R4 mix");
        lv[5] = 128;
        pix_level[5*LVL_W +: LVL_W] = 9'd128;
        run_frame(1'b0, 1'b0, "R8 restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule